// File: doc/BRIEF.md
# Hierarchical Token-Ring Frame Serialiser

This block turns a 66-bit parallel frame into a serial stream, one bit per clock. The frame has two framing bits in positions 1:0 and 64 payload bits in positions 65:2, in the 64b/66b style. The framing bits travel in the stream like any other bit, so the clock never stops and no gap cycles are inserted between frames. Internally the frame is split into its even-indexed and odd-indexed bits. Each 33-bit half feeds its own branch. A branch is built from three 11-element token rings, which are chosen in turn by a 3-element token ring. In every ring the one element that holds the token drives a shared bus. A final two-way selector interleaves the two branch buses.

A user presents a frame and pulses the load strobe in the cycle that drives bit 65 of the current frame. Bit 0 of the new frame follows in the very next cycle. If no frame is offered at that boundary, the captured frame is sent again. A strobe at any other time is ignored and sets an error flag that stays set until reset. A frame-start output marks the cycle that carries bit 0.

Top module: `frameSerializer`

## Requirements
- R1: The serial output carries frame bit 0 in the first cycle of a frame, then bit 1, and so on up to bit 65, one bit per clock. Each even-indexed bit comes out in the cycle just before the odd-indexed bit that follows it.
- R2: Frames follow each other with no idle cycles, so every frame takes exactly 66 clocks. The framing bits 1:0 are sent inside those 66 cycles.
- R3: `frameStart` is 1 only in the cycle that drives bit 0 of a frame, and 0 in the other 65 cycles.
- R4: A `loadStrobe` given in the cycle that drives bit 65 captures `frameIn`. That frame's bit 0 is driven in the next cycle.
- R5: A `loadStrobe` in any other cycle is ignored: the current frame and the next frame are unchanged. It also sets `loadError`, which stays 1 until reset.
- R6: When no frame is loaded at the boundary, the last captured frame is sent again.
- R7: While reset (`rstN` low) is active and in the first cycle after it, the held frame is all zeros, the position is bit 0 (`frameStart` = 1, `serOut` = 0), and `loadError` is 0.
- R8: Every token ring holds exactly one token. After reset the token is at element 0. It moves one place only when its ring is selected and wraps from the last element back to element 0. All rings are at element 0 at every frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameIn | input | 66 | Parallel frame; bit 0 is sent first, bits 1:0 are the framing bits |
| loadStrobe | input | 1 | Capture request, valid only in the cycle that drives bit 65 |
| serOut | output | 1 | Serial data bit |
| frameStart | output | 1 | High in the cycle that drives bit 0 |
| loadError | output | 1 | Sticky flag for a strobe given off the boundary |

## Verification
The bench builds the block with its default geometry: rings of 11 elements and 3 sub-serialisers per branch, giving a 66-bit frame. With these values every frame takes each inner ring and each selector ring all the way around once, so wrap errors at both levels show up as wrong bits in the recovered frame. The bench sends patterned frames back to back and rebuilds each one from the serial stream. It then checks three further cases: a frame that repeats because no load was given, a strobe given in the middle of a frame, and a strobe given on bit 0.

// File: rtl/serPkg.sv
`timescale 1ns/1ps
package serPkg;
  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;        // capture the parallel frame at this edge
    logic advEven;     // even branch emits this cycle and advances its tokens
    logic advOdd;      // odd branch emits this cycle and advances its tokens
    logic oddPhase;    // output selector picks the odd branch
    logic frameStart;  // this cycle carries bit 0
  } ctlStrobes_t;
endpackage

// File: rtl/tokenRing.sv
`timescale 1ns/1ps
module tokenRing #(
  parameter int LEN = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           advance,
  output logic [LEN-1:0] token
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) token <= {{(LEN-1){1'b0}}, 1'b1};
    else if (advance) token <= {token[LEN-2:0], token[LEN-1]};
  end

  AST_TOKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(token)); // R8
  AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(token)); // R8
  AST_TOKEN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && token[LEN-1]) |=> token[0]); // R8
endmodule

// File: rtl/serBranch.sv
`timescale 1ns/1ps
module serBranch #(
  parameter int SUB_LEN = 11,
  parameter int NUM_SUB = 3,
  localparam int HALF = SUB_LEN * NUM_SUB
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  logic [HALF-1:0] bits,
  output logic            bitOut,
  output logic            homeFlag
);
  logic [NUM_SUB-1:0] outerTok;
  logic [NUM_SUB-1:0] innerLast;
  logic [NUM_SUB-1:0] innerHome;
  logic [NUM_SUB-1:0] subBit;
  logic               outerAdv;

  for (genvar s = 0; s < NUM_SUB; s++) begin : gSub
    logic [SUB_LEN-1:0] innerTok;
    logic               innerBus;

    tokenRing #(.LEN(SUB_LEN)) i_inner (
      .clk    (clk),
      .rstN   (rstN),
      .advance(advance & outerTok[s]),
      .token  (innerTok)
    );

    // shared bus of this sub-serialiser: only the token holder drives it
    assign innerBus     = |(innerTok & bits[s*SUB_LEN +: SUB_LEN]);
    assign subBit[s]    = innerBus & outerTok[s];
    assign innerLast[s] = innerTok[SUB_LEN-1];
    assign innerHome[s] = innerTok[0];
  end

  // the selector ring moves on when the chosen sub-ring hands back its token
  assign outerAdv = advance & |(outerTok & innerLast);

  tokenRing #(.LEN(NUM_SUB)) i_outer (
    .clk    (clk),
    .rstN   (rstN),
    .advance(outerAdv),
    .token  (outerTok)
  );

  assign bitOut   = |subBit;
  assign homeFlag = outerTok[0] & (&innerHome);
endmodule

// File: rtl/serControl.sv
`timescale 1ns/1ps
module serControl
  import serPkg::*;
#(
  parameter int FRAME = 66,
  localparam int POS_W = $clog2(FRAME)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  output ctlStrobes_t ctl,
  output logic        loadError
);
  logic [POS_W-1:0] pos;
  logic             atBoundary;

  assign atBoundary = (pos == POS_W'(FRAME-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pos <= '0;
    else if (atBoundary) pos <= '0;
    else pos <= pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadError <= 1'b0;
    else if (loadStrobe && !atBoundary) loadError <= 1'b1;
  end

  always_comb begin
    ctl.load       = loadStrobe & atBoundary;
    ctl.oddPhase   = pos[0];
    ctl.advEven    = ~pos[0];
    ctl.advOdd     = pos[0];
    ctl.frameStart = (pos == '0);
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadError |=> loadError); // R5
  AST_BAD_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && !atBoundary) |=> loadError); // R5
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    atBoundary |=> ctl.frameStart); // R2
endmodule

// File: rtl/serDatapath.sv
`timescale 1ns/1ps
module serDatapath
  import serPkg::*;
#(
  parameter int SUB_LEN = 11,
  parameter int NUM_SUB = 3,
  localparam int HALF  = SUB_LEN * NUM_SUB,
  localparam int FRAME = 2 * HALF
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [FRAME-1:0] frameIn,
  output logic             serOut
);
  logic [FRAME-1:0] frameReg;
  logic [HALF-1:0]  evenBits;
  logic [HALF-1:0]  oddBits;
  logic             evenBit, oddBit;
  logic             evenHome, oddHome;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameReg <= '0;
    else if (ctl.load) frameReg <= frameIn;
  end

  for (genvar k = 0; k < HALF; k++) begin : gSplit
    assign evenBits[k] = frameReg[2*k];
    assign oddBits[k]  = frameReg[2*k+1];
  end

  serBranch #(.SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB)) i_evenBranch (
    .clk     (clk),
    .rstN    (rstN),
    .advance (ctl.advEven),
    .bits    (evenBits),
    .bitOut  (evenBit),
    .homeFlag(evenHome)
  );

  serBranch #(.SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB)) i_oddBranch (
    .clk     (clk),
    .rstN    (rstN),
    .advance (ctl.advOdd),
    .bits    (oddBits),
    .bitOut  (oddBit),
    .homeFlag(oddHome)
  );

  assign serOut = ctl.oddPhase ? oddBit : evenBit;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> frameReg == $past(frameIn)); // R4
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(frameReg)); // R6
  AST_RINGS_HOME: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameStart |-> (evenHome && oddHome)); // R8
endmodule

// File: rtl/frameSerializer.sv
`timescale 1ns/1ps
module frameSerializer
  import serPkg::*;
#(
  parameter int SUB_LEN = 11,
  parameter int NUM_SUB = 3,
  localparam int FRAME = 2 * SUB_LEN * NUM_SUB
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FRAME-1:0] frameIn,
  input  logic             loadStrobe,
  output logic             serOut,
  output logic             frameStart,
  output logic             loadError
);
  ctlStrobes_t ctl;

  serControl #(.FRAME(FRAME)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .loadStrobe(loadStrobe),
    .ctl       (ctl),
    .loadError (loadError)
  );

  serDatapath #(.SUB_LEN(SUB_LEN), .NUM_SUB(NUM_SUB)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .frameIn(frameIn),
    .serOut (serOut)
  );

  assign frameStart = ctl.frameStart;
endmodule

// File: tb/test_frameSerializer.sv
`timescale 1ns/1ps
module test_frameSerializer;
  localparam int FRAME  = 66;
  localparam int PERIOD = 20;
  localparam int NVEC   = 6;

  localparam logic [FRAME-1:0] VEC [NVEC] = '{
    66'h1_0123456789ABCDEF,
    66'h2_FFFFFFFFFFFFFFFF,
    66'h1_5555555555555555,
    66'h2_8000000000000001,
    66'h3_DEADBEEFCAFEF00D,
    66'h2_0000000000000002
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStrobe = 1'b0;
  logic [FRAME-1:0] frameIn = '0;
  logic serOut, frameStart, loadError;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  frameSerializer i_frameSerializer (
    .clk       (clk),
    .rstN      (rstN),
    .frameIn   (frameIn),
    .loadStrobe(loadStrobe),
    .serOut    (serOut),
    .frameStart(frameStart),
    .loadError (loadError)
  );

  task automatic checkBit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Called at a negedge in the cycle that drives bit 0. Rebuilds one frame from
  // the stream, optionally loads the next one at bit 65, and optionally gives
  // a misplaced strobe at bit index badAt.
  task automatic playFrame(input logic [FRAME-1:0] expFrame, input bit doLoad,
                           input logic [FRAME-1:0] nextData, input int badAt,
                           input string tag);
    logic [FRAME-1:0] got;
    int startErr;
    startErr = 0;
    for (int i = 0; i < FRAME; i++) begin
      got[i] = serOut;
      if (frameStart !== (i == 0)) startErr++;
      if (i == FRAME-1 && doLoad) begin
        loadStrobe = 1'b1;
        frameIn    = nextData;
      end else if (i == badAt) begin
        loadStrobe = 1'b1;
        frameIn    = ~expFrame;
      end
      @(posedge clk);
      @(negedge clk);
      loadStrobe = 1'b0;
    end
    checks++;
    if (got !== expFrame) begin
      failures++;
      $display("FAIL R1 R8 %s actual=%h expected=%h", tag, got, expFrame);
    end
    checks++;
    if (startErr != 0) begin
      failures++;
      $display("FAIL R3 %s frameStart mismatches actual=%0d expected=0", tag, startErr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: state during reset
    checkBit(frameStart, 1'b1, "R7 frameStart in reset");
    checkBit(serOut, 1'b0, "R7 serOut in reset");
    checkBit(loadError, 1'b0, "R7 loadError in reset");
    rstN = 1'b1;
    // R7: the first frame after reset is all zeros; R4 load of the first vector
    playFrame('0, 1'b1, VEC[0], -1, "R7 zero frame after reset");
    // R2 R4: table frames back to back, each loaded at the boundary
    for (int v = 0; v < NVEC; v++) begin
      playFrame(VEC[v], v < NVEC-1, (v < NVEC-1) ? VEC[v+1] : '0, -1,
                "R2 R4 back-to-back table frame");
    end
    // R6: nothing was loaded, so the last frame repeats; R5 strobe at bit 10
    playFrame(VEC[NVEC-1], 1'b1, VEC[0], 10, "R6 repeat with R5 strobe at bit 10");
    checkBit(loadError, 1'b1, "R5 loadError after misplaced strobe");
    // R4: a proper load still works while the error flag is set
    playFrame(VEC[0], 1'b0, '0, 0, "R4 load after error, R5 strobe at bit 0");
    checkBit(loadError, 1'b1, "R5 loadError stays set");
    // R5 R6: the strobe at bit 0 did not replace the frame
    playFrame(VEC[0], 1'b0, '0, -1, "R5 R6 frame unchanged after bit-0 strobe");
    checkBit(loadError, 1'b1, "R5 loadError sticky at end");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule